// File: doc/BRIEF.md
# RS485 Auto-Direction Line Controller

This block sits next to a UART transmitter and drives the driver-enable line of an RS485 transceiver, which shares the RTS pin with ordinary modem control. In automatic mode the line goes active in the same cycle that the transmitter reports busy, with no lead time. It stays active while characters keep coming. Once the transmitter is idle and its FIFO is empty, the line stays active for a programmed number of bit times and then drops. When automatic mode is off, or its output is not routed to the pin, the pin carries the software-controlled modem RTS level.

The block takes a settings word, a strobe that writes it, a one-clock bit-time tick from the baud generator, and the transmitter's busy and FIFO-empty flags. A status output is high while the release countdown runs. A settings write made during a transmission is held back and applied once the transmitter goes idle.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: While `rst_n` is low, `rts_pin` is 0 and `dly_active` is 0. Reset restores the settings word to all zeros.
- R2: Settings word layout: bit 0 turns automatic control on, bit 1 routes it to the pin, bit 2 inverts the output level, and bits 11:8 hold the release delay in bit times (0 to 15). All other bits are ignored.
- R3: When bit 0 or bit 1 of the applied settings is clear, `rts_pin` equals `modem_rts`, whatever the transmitter flags and ticks do.
- R4: In automatic mode with bit 2 clear, `rts_pin` is 1 in the same cycle that `tx_busy` is 1. There is no delay before sending.
- R5: With bit 2 set, every automatic output level is inverted: 0 while active and 1 while inactive.
- R6: Suppose a clock edge samples `tx_busy` low and `tx_fifo_empty` high while sending with a delay D of 1 or more. After that edge `dly_active` is 1 and the line stays active. The line is released after the edge that samples the D-th `bit_tick` counted from then on.
- R7: With a delay of 0, the line is released after the first edge that samples `tx_busy` low with `tx_fifo_empty` high, and `dly_active` stays 0.
- R8: While `tx_busy` is low but `tx_fifo_empty` is low, the line stays active and no countdown runs.
- R9: If `tx_busy` rises during a countdown, the countdown is dropped (`dly_active` goes 0 after that edge) and the line stays active without a gap. The next release waits for a full D ticks again.
- R10: A write made while `tx_busy` is high does not change the applied settings until an edge that samples `tx_busy` low. A write made while idle applies after that edge.
- R11: `bit_tick` pulses have no effect outside a countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Settings write strobe |
| cfg_wdata | input | CFG_W | Settings word to write |
| bit_tick | input | 1 | One-clock pulse per bit time |
| tx_busy | input | 1 | Transmitter shifting (start bit through last stop bit) |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no characters |
| modem_rts | input | 1 | Software RTS level used in bypass |
| rts_pin | output | 1 | RTS / driver-enable pin |
| dly_active | output | 1 | Release countdown in progress |

## Verification
The hardest case to reach from the ports is a new character that arrives partway through a release countdown. The stimulus sets a long delay and ends a character. It waits two ticks, so the countdown is visibly running, then raises `tx_busy` again and checks that the line never drops and that the following release takes the full count. A second hard case is a settings write that lands during a transmission. The bench writes an inverted polarity mid-character and checks that the pin level stays the same until the transmitter idles.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

   typedef enum logic [1:0] {
      DIR_IDLE = 2'd0,
      DIR_SEND = 2'd1,
      DIR_HOLD = 2'd2
   } dir_state_e;

   localparam int unsigned DEF_CFG_W     = 16;
   localparam int unsigned DEF_DLY_W     = 4;
   localparam int unsigned DEF_DLY_LSB   = 8;
   localparam int unsigned DEF_EN_BIT    = 0;
   localparam int unsigned DEF_ROUTE_BIT = 1;
   localparam int unsigned DEF_POL_BIT   = 2;

endpackage

// File: rtl/rs485_cfg_shadow.sv
module rs485_cfg_shadow #(
   parameter int unsigned      CFG_W   = 16,
   parameter logic [CFG_W-1:0] RST_CFG = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CFG_W-1:0] wdata,
   input  logic             tx_busy,
   output logic [CFG_W-1:0] cfg_q
);

   logic             pend_q;
   logic [CFG_W-1:0] pend_data_q;

   initial assert (CFG_W >= 1) else $error("CFG_W must be at least 1");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q       <= RST_CFG;
         pend_q      <= 1'b0;
         pend_data_q <= '0;
      end else if (wr && tx_busy) begin
         pend_q      <= 1'b1;
         pend_data_q <= wdata;
      end else if (wr) begin
         cfg_q  <= wdata;
         pend_q <= 1'b0;
      end else if (pend_q && !tx_busy) begin
         cfg_q  <= pend_data_q;
         pend_q <= 1'b0;
      end
   end

   // R10: settings never change across an edge that sees the transmitter busy
   a_r10_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |=> $stable(cfg_q));

endmodule

// File: rtl/rs485_release_timer.sv
module rs485_release_timer
   import rs485_dir_pkg::*;
#(
   parameter int unsigned DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             auto_en,
   input  logic [DLY_W-1:0] dly,
   input  logic             bit_tick,
   input  logic             tx_busy,
   input  logic             tx_fifo_empty,
   output logic             dir_active,
   output logic             hold_active
);

   localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

   dir_state_e       state_q, state_d;
   logic [DLY_W-1:0] cnt_q, cnt_d;
   logic             drained;

   initial assert (DLY_W >= 1 && DLY_W <= 16) else $error("DLY_W out of range");

   assign drained = !tx_busy && tx_fifo_empty;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      if (!auto_en) begin
         state_d = DIR_IDLE;
         cnt_d   = '0;
      end else begin
         unique case (state_q)
            DIR_IDLE: if (tx_busy) state_d = DIR_SEND;
            DIR_SEND: begin
               if (drained) begin
                  if (dly == '0) begin
                     state_d = DIR_IDLE;
                  end else begin
                     state_d = DIR_HOLD;
                     cnt_d   = dly;
                  end
               end
            end
            DIR_HOLD: begin
               if (!drained) begin
                  state_d = DIR_SEND;
                  cnt_d   = '0;
               end else if (bit_tick) begin
                  cnt_d = cnt_q - ONE;
                  if (cnt_q == ONE) state_d = DIR_IDLE;
               end
            end
            default: begin
               state_d = DIR_IDLE;
               cnt_d   = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DIR_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign dir_active  = tx_busy || (state_q != DIR_IDLE);
   assign hold_active = (state_q == DIR_HOLD);

   // R9: a busy transmitter always cancels the countdown at the next edge
   a_r9_busy_cancels: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |=> !hold_active);

   // R6: without a tick the countdown cannot finish
   a_r6_no_tick_no_release: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_active && auto_en && drained && !bit_tick) |=> hold_active);

   // R7: a zero delay never starts a countdown
   a_r7_zero_never_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (dly == '0 && !hold_active) |=> !hold_active);

   // R11: ticks outside a countdown do not start one
   a_r11_idle_tick_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_active && bit_tick) |=> !hold_active);

endmodule

// File: rtl/rs485_pin_mux.sv
module rs485_pin_mux #(
   parameter logic RST_LVL = 1'b0
) (
   input  logic rst_n,
   input  logic auto_route,
   input  logic pol_inv,
   input  logic dir_active,
   input  logic modem_rts,
   output logic rts_pin
);

   always_comb begin
      if (!rst_n)          rts_pin = RST_LVL;
      else if (auto_route) rts_pin = dir_active ^ pol_inv;
      else                 rts_pin = modem_rts;
   end

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
   import rs485_dir_pkg::*;
#(
   parameter int unsigned      CFG_W     = DEF_CFG_W,
   parameter int unsigned      DLY_W     = DEF_DLY_W,
   parameter int unsigned      DLY_LSB   = DEF_DLY_LSB,
   parameter int unsigned      EN_BIT    = DEF_EN_BIT,
   parameter int unsigned      ROUTE_BIT = DEF_ROUTE_BIT,
   parameter int unsigned      POL_BIT   = DEF_POL_BIT,
   parameter logic [CFG_W-1:0] RST_CFG   = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             bit_tick,
   input  logic             tx_busy,
   input  logic             tx_fifo_empty,
   input  logic             modem_rts,
   output logic             rts_pin,
   output logic             dly_active
);

   localparam int unsigned DLY_MSB = DLY_LSB + DLY_W - 1;
   localparam logic        RST_LVL = RST_CFG[POL_BIT];

   initial begin
      assert (DLY_MSB < CFG_W) else $error("delay field outside settings word");
      assert (EN_BIT < CFG_W && ROUTE_BIT < CFG_W && POL_BIT < CFG_W)
         else $error("control bit outside settings word");
   end

   logic [CFG_W-1:0] cfg_q;
   logic             auto_en, auto_route, pol_inv, dir_active;
   logic [DLY_W-1:0] dly;

   rs485_cfg_shadow #(.CFG_W(CFG_W), .RST_CFG(RST_CFG)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
      .tx_busy(tx_busy), .cfg_q(cfg_q)
   );

   assign auto_en    = cfg_q[EN_BIT];
   assign auto_route = cfg_q[EN_BIT] && cfg_q[ROUTE_BIT];
   assign pol_inv    = cfg_q[POL_BIT];
   assign dly        = cfg_q[DLY_MSB:DLY_LSB];

   rs485_release_timer #(.DLY_W(DLY_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .dly(dly),
      .bit_tick(bit_tick), .tx_busy(tx_busy), .tx_fifo_empty(tx_fifo_empty),
      .dir_active(dir_active), .hold_active(dly_active)
   );

   rs485_pin_mux #(.RST_LVL(RST_LVL)) u_mux (
      .rst_n(rst_n), .auto_route(auto_route), .pol_inv(pol_inv),
      .dir_active(dir_active), .modem_rts(modem_rts), .rts_pin(rts_pin)
   );

   // R6: the pin holds its active level for the whole countdown
   a_r6_pin_held: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_route && dly_active) |-> (rts_pin == !pol_inv));

   // R4: the pin is active whenever the transmitter is busy
   a_r4_active_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_route && tx_busy) |-> (rts_pin == !pol_inv));

endmodule

// File: tb/rs485_dir_ctrl_tb.sv
module rs485_dir_ctrl_tb;

   localparam int TICKP = 4;
   localparam int WD    = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic        bit_tick = 1'b0;
   logic        tx_busy = 1'b0;
   logic        tx_fifo_empty = 1'b1;
   logic        modem_rts = 1'b0;
   logic        rts_pin, dly_active;

   int    n_chk = 0, n_bad = 0, cyc = 0, tick_ph = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   rs485_dir_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .bit_tick(bit_tick), .tx_busy(tx_busy), .tx_fifo_empty(tx_fifo_empty),
      .modem_rts(modem_rts), .rts_pin(rts_pin), .dly_active(dly_active)
   );

   // behavioural reference: phase 0 quiet, 1 talking, 2 waiting out the delay
   bit          m_on, m_out, m_inv, m_pend;
   int          m_delay, m_phase, m_left;
   logic [15:0] m_pword;

   task automatic take(input logic [15:0] w);
      m_on = w[0]; m_out = w[1]; m_inv = w[2]; m_delay = int'(w[11:8]);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         take(16'h0); m_pend = 0; m_phase = 0; m_left = 0;
      end else begin
         if (!m_on) begin
            m_phase = 0; m_left = 0;
         end else if (m_phase == 0) begin
            if (tx_busy) m_phase = 1;
         end else if (m_phase == 1) begin
            if (!tx_busy && tx_fifo_empty) begin
               m_left  = m_delay;
               m_phase = (m_delay == 0) ? 0 : 2;
            end
         end else begin
            if (tx_busy || !tx_fifo_empty) begin
               m_phase = 1; m_left = 0;
            end else if (bit_tick) begin
               m_left = m_left - 1;
               if (m_left == 0) m_phase = 0;
            end
         end
         if (cfg_wr && tx_busy) begin
            m_pend = 1; m_pword = cfg_wdata;
         end else if (cfg_wr) begin
            take(cfg_wdata); m_pend = 0;
         end else if (m_pend && !tx_busy) begin
            take(m_pword); m_pend = 0;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD) begin
         n_bad++;
         $display("FAIL watchdog expired (%s) actual=%0d expected<=%0d", cur_req, cyc, WD);
         finish_run();
      end
   end

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic compare();
      logic ep, ed;
      if (!rst_n)               ep = 1'b0;
      else if (m_on && m_out)   ep = ((tx_busy || m_phase != 0) ? 1'b1 : 1'b0) ^ m_inv;
      else                      ep = modem_rts;
      ed = rst_n && (m_phase == 2);
      n_chk++;
      if (rts_pin !== ep) begin
         n_bad++;
         $display("FAIL %s rts_pin actual=%b expected=%b at cycle %0d", cur_req, rts_pin, ep, cyc);
      end
      n_chk++;
      if (dly_active !== ed) begin
         n_bad++;
         $display("FAIL %s dly_active actual=%b expected=%b at cycle %0d", cur_req, dly_active, ed, cyc);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare();
         cfg_wr   = 1'b0;
         bit_tick = (tick_ph == TICKP - 1);
         tick_ph  = (tick_ph + 1) % TICKP;
         #1 compare();
      end
   endtask

   task automatic write_cfg(input logic [15:0] w);
      @(negedge clk);
      compare();
      cfg_wr = 1'b1; cfg_wdata = w;
      #1 compare();
      step(1);
   endtask

   task automatic send(input int len);
      @(negedge clk);
      compare();
      tx_busy = 1'b1;
      #1 compare();
      step(len);
      @(negedge clk);
      compare();
      tx_busy = 1'b0;
      #1 compare();
   endtask

   initial begin
      cur_req = "R1";
      modem_rts = 1'b1;
      step(3);
      @(negedge clk);
      compare();
      rst_n = 1'b1;
      #1 compare();

      // R3: bypass with settings cleared and with partial settings
      cur_req = "R3";
      for (int k = 0; k < 6; k++) begin
         modem_rts = k[0];
         send(3);
         step(5);
      end
      write_cfg(16'h0301);
      send(4); modem_rts = 1'b0; step(20); modem_rts = 1'b1; step(3);
      write_cfg(16'h0302);
      send(4); step(20);
      modem_rts = 1'b0;

      // R4 and R6: delay of three bit times, normal polarity
      cur_req = "R4";
      write_cfg(16'h0303);
      send(10);
      cur_req = "R6";
      modem_rts = 1'b1;
      step(20);
      modem_rts = 1'b0;

      // R7: zero delay
      cur_req = "R7";
      write_cfg(16'h0003);
      send(9); step(10);

      // R6: maximum delay of fifteen
      cur_req = "R6";
      write_cfg(16'h0F03);
      send(7); step(70);

      // R5: inverted level
      cur_req = "R5";
      write_cfg(16'h0207);
      send(8); step(15);

      // R8: FIFO still holds data between characters
      cur_req = "R8";
      write_cfg(16'h0203);
      tx_fifo_empty = 1'b0;
      send(10); step(14);
      send(6);
      tx_fifo_empty = 1'b1;
      step(15);

      // R9: restart during countdown
      cur_req = "R9";
      write_cfg(16'h0803);
      send(5); step(9);
      send(5); step(45);

      // R10: write during a transmission is deferred
      cur_req = "R10";
      write_cfg(16'h0303);
      @(negedge clk); compare(); tx_busy = 1'b1; #1 compare();
      step(3);
      @(negedge clk); compare(); cfg_wr = 1'b1; cfg_wdata = 16'h0107; #1 compare();
      step(8);
      @(negedge clk); compare(); tx_busy = 1'b0; #1 compare();
      step(12);
      send(4); step(10);

      // R2: unused bits set, delay field of four
      cur_req = "R2";
      write_cfg(16'hF4FB);
      send(6); step(25);

      // R11: ticks while quiet
      cur_req = "R11";
      step(30);

      finish_run();
   end

endmodule